// File: doc/BRIEF.md
# Shortened Reed-Solomon Symbol ECC Encoder

This block turns a 128-bit data word into a 144-bit protected codeword. It splits the word into sixteen 8-bit symbols. Each symbol is an element of GF(2^8), built on the primitive polynomial x^8 + x^4 + x^3 + x^2 + 1 (reduction constant 0x11D). From these symbols the block computes two 8-bit check symbols. The result is a Reed-Solomon code cut down to 18 symbols, and it can correct any one corrupted symbol. The binary image of this code also lets a simpler decoder correct single-bit errors and detect double-bit errors. The two check symbols are therefore the only redundancy written to storage, and the storage overhead is 12.5%.

The two rows of the parity-check matrix give column j as (1, alpha^j) for j = 0..17, with alpha = 0x02. The check symbols are chosen so that both weighted sums over the codeword come to zero. All the field arithmetic uses multipliers by fixed constants, each built as an XOR network. The data path has no clock. A parameter can add one output register stage. That register captures a codeword only when a valid strobe is present.

Top module: `symbol_ecc_encoder`

## Requirements
- R1: `out_code[127:0]` carries the data word unchanged. Data symbol k occupies bits 8k+7:8k, for k = 0..15.
- R2: In GF(2^8), addition is bitwise XOR. The XOR of all 18 symbols of every produced codeword is zero. Check symbol 16 is `out_code[135:128]` and check symbol 17 is `out_code[143:136]`.
- R3: For every produced codeword, the GF(2^8) sum over j = 0..17 of alpha^j times symbol j is zero. Here alpha = 0x02, and products are reduced by 0x11D.
- R4: An all-zero data word yields all-zero check symbols.
- R5: The encoding is linear. The codeword of (a XOR b) equals the XOR of the codewords of a and b.
- R6: With `REG_OUT` = 1, a word presented with `in_valid` high at a rising edge appears on `out_code` after that edge. At the same edge `out_valid` goes high, and it falls at the next edge if `in_valid` is low then. With `REG_OUT` = 0, the outputs follow the inputs with no clock.
- R7: With `REG_OUT` = 1, the registered codeword keeps its value while `in_valid` is low, whatever `in_data` does.
- R8: While `rst_n` is low, and after reset before any accepted word, `out_valid` is 0 and `out_code` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| in_valid | input | 1 | Marks `in_data` as a word to encode |
| in_data | input | 128 | Sixteen 8-bit data symbols |
| out_valid | output | 1 | Marks `out_code` as a fresh codeword |
| out_code | output | 144 | Data symbols followed by check symbols 16 and 17 |

## Verification
The bench drives several kinds of data words:
- The all-zero word, which catches a stray constant term in the check logic.
- The all-ones word, which exercises every multiplier column at once.
- All 128 single-bit words. Each of these hits exactly one column of one constant multiplier, so a wrong alpha power, a swapped check position or a bad reduction constant shows up as a nonzero syndrome.

Random pairs, together with their XOR, test linearity; an inverted or constant check bit breaks it. Further scenarios check output latency, valid timing and how the register holds its value while the strobe is low. A register that loaded on every cycle, or whose valid output lagged by a cycle, would report wrong words or misplaced strobes.

// File: rtl/rs_enc_pkg.sv
package rs_enc_pkg;

    localparam int SYM_W     = 8;
    localparam int CHK_SYMS  = 2;
    localparam logic [SYM_W-1:0] POLY_LOW = 8'h1D;  // x^8 = x^4+x^3+x^2+1
    localparam logic [SYM_W-1:0] ALPHA    = 8'h02;

    typedef logic [SYM_W-1:0] sym_t;

    // GF(2^8) product, shift-and-add with modular reduction
    function automatic sym_t gf_mul(input sym_t a, input sym_t b);
        sym_t acc;
        sym_t x;
        acc = '0;
        x   = a;
        for (int i = 0; i < SYM_W; i++) begin
            if (b[i]) acc = acc ^ x;
            x = x[SYM_W-1] ? ((x << 1) ^ POLY_LOW) : (x << 1);
        end
        return acc;
    endfunction

    // alpha raised to a non-negative power
    function automatic sym_t gf_pow(input int e);
        sym_t r;
        r = 8'h01;
        for (int i = 0; i < e; i++) r = gf_mul(r, ALPHA);
        return r;
    endfunction

    // multiplicative inverse as a^254
    function automatic sym_t gf_inv(input sym_t a);
        sym_t r;
        r = 8'h01;
        for (int i = 0; i < 254; i++) r = gf_mul(r, a);
        return r;
    endfunction

endpackage

// File: rtl/gf_const_mul.sv
module gf_const_mul
    import rs_enc_pkg::*;
#(
    parameter sym_t K = 8'h01
) (
    input  sym_t a,
    output sym_t y
);

    sym_t part [SYM_W];

    // each input bit selects one precomputed column K * x^i
    for (genvar i = 0; i < SYM_W; i++) begin : g_col
        localparam sym_t COL = gf_mul(K, sym_t'(1) << i);
        assign part[i] = a[i] ? COL : '0;
    end

    always_comb begin
        y = '0;
        for (int i = 0; i < SYM_W; i++) y = y ^ part[i];
    end

endmodule

// File: rtl/rs_syn_accum.sv
module rs_syn_accum
    import rs_enc_pkg::*;
#(
    parameter int NSYM = 16
) (
    input  logic [NSYM*SYM_W-1:0] data,
    output sym_t                  s_plain,
    output sym_t                  s_weighted
);

    sym_t weighted [NSYM];

    for (genvar k = 0; k < NSYM; k++) begin : g_sym
        gf_const_mul #(.K(gf_pow(k))) u_mul (
            .a (data[k*SYM_W +: SYM_W]),
            .y (weighted[k])
        );
    end

    always_comb begin
        s_plain    = '0;
        s_weighted = '0;
        for (int k = 0; k < NSYM; k++) begin
            s_plain    = s_plain ^ data[k*SYM_W +: SYM_W];
            s_weighted = s_weighted ^ weighted[k];
        end
    end

endmodule

// File: rtl/rs_check_solve.sv
module rs_check_solve
    import rs_enc_pkg::*;
#(
    parameter int POS_A = 16
) (
    input  sym_t s_plain,
    input  sym_t s_weighted,
    output sym_t chk_a,
    output sym_t chk_b
);

    // chk_a + chk_b = s_plain
    // a^P chk_a + a^(P+1) chk_b = s_weighted
    // => chk_b = (s_weighted + a^P s_plain) / (a^P (1 + a))
    localparam sym_t POW_A = gf_pow(POS_A);
    localparam sym_t DEN   = gf_mul(POW_A, ALPHA ^ 8'h01);
    localparam sym_t DEN_I = gf_inv(DEN);

    sym_t scaled;
    sym_t numer;

    gf_const_mul #(.K(POW_A)) u_scale (.a(s_plain), .y(scaled));

    assign numer = s_weighted ^ scaled;

    gf_const_mul #(.K(DEN_I)) u_div (.a(numer), .y(chk_b));

    assign chk_a = s_plain ^ chk_b;

endmodule

// File: rtl/symbol_ecc_encoder.sv
module symbol_ecc_encoder
    import rs_enc_pkg::*;
#(
    parameter int DATA_SYMS = 16,
    parameter bit REG_OUT   = 1'b1
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    in_valid,
    input  logic [DATA_SYMS*SYM_W-1:0]              in_data,
    output logic                                    out_valid,
    output logic [(DATA_SYMS+CHK_SYMS)*SYM_W-1:0]   out_code
);

    localparam int DATA_W = DATA_SYMS * SYM_W;
    localparam int CODE_W = (DATA_SYMS + CHK_SYMS) * SYM_W;
    localparam int NTOT   = DATA_SYMS + CHK_SYMS;

    sym_t s_plain;
    sym_t s_weighted;
    sym_t chk_a;
    sym_t chk_b;
    logic [CODE_W-1:0] code_next;

    rs_syn_accum #(.NSYM(DATA_SYMS)) u_acc (
        .data       (in_data),
        .s_plain    (s_plain),
        .s_weighted (s_weighted)
    );

    rs_check_solve #(.POS_A(DATA_SYMS)) u_solve (
        .s_plain    (s_plain),
        .s_weighted (s_weighted),
        .chk_a      (chk_a),
        .chk_b      (chk_b)
    );

    assign code_next = {chk_b, chk_a, in_data};

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                out_valid <= 1'b0;
                out_code  <= '0;
            end else begin
                out_valid <= in_valid;
                if (in_valid) out_code <= code_next;
            end
        end

        AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid); // R6
        AST_VALID_FALL: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid); // R6
        AST_DATA_PASS: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> (out_code[DATA_W-1:0] == $past(in_data))); // R1
        AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> $stable(out_code)); // R7
    end else begin : g_comb
        assign out_valid = in_valid;
        assign out_code  = code_next;
    end

    // independent syndrome of the driven codeword, used only by the checks
    sym_t chk_syn0;
    sym_t chk_syn1;
    always_comb begin
        chk_syn0 = '0;
        chk_syn1 = '0;
        for (int j = 0; j < NTOT; j++) begin
            chk_syn0 = chk_syn0 ^ out_code[j*SYM_W +: SYM_W];
            chk_syn1 = chk_syn1 ^ gf_mul(gf_pow(j), out_code[j*SYM_W +: SYM_W]);
        end
    end

    AST_SYN_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (chk_syn0 == '0)); // R2
    AST_SYN_WEIGHTED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (chk_syn1 == '0)); // R3

endmodule

// File: tb/symbol_ecc_encoder_tb_top.sv
module symbol_ecc_encoder_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] in_data = '0;
    logic         out_valid;
    logic [143:0] out_code;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    symbol_ecc_encoder #(.DATA_SYMS(16), .REG_OUT(1'b1)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_code  (out_code)
    );

    function automatic logic [7:0] tb_gmul(input logic [7:0] a, input logic [7:0] b);
        logic [15:0] p;
        p = '0;
        for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
        for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h011D << (i - 8));
        return p[7:0];
    endfunction

    function automatic logic [15:0] tb_syn(input logic [143:0] cw);
        logic [7:0] s0;
        logic [7:0] s1;
        logic [7:0] w;
        s0 = '0; s1 = '0; w = 8'h01;
        for (int j = 0; j < 18; j++) begin
            s0 = s0 ^ cw[j*8 +: 8];
            s1 = s1 ^ tb_gmul(w, cw[j*8 +: 8]);
            w  = tb_gmul(w, 8'h02);
        end
        return {s1, s0};
    endfunction

    task automatic expect_eq(input string req, input logic [143:0] act, input logic [143:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(input logic [127:0] d, output logic [143:0] cw);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        @(negedge clk);
        in_valid = 1'b0;
        cw = out_code;
        expect_eq("R6", 144'(out_valid), 144'd1);
    endtask

    task automatic check_code(input logic [127:0] d, input logic [143:0] cw);
        logic [15:0] s;
        s = tb_syn(cw);
        expect_eq("R1", 144'(cw[127:0]), 144'(d));
        expect_eq("R2", 144'(s[7:0]), 144'd0);
        expect_eq("R3", 144'(s[15:8]), 144'd0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        expect_eq("R8", 144'(out_valid), 144'd0);
        expect_eq("R8", out_code, 144'd0);
        rst_n = 1'b1;
        @(negedge clk);
        expect_eq("R8", 144'(out_valid), 144'd0);
        expect_eq("R8", out_code, 144'd0);
    endtask

    task automatic t_zero;
        logic [143:0] cw;
        push('0, cw);
        check_code('0, cw);
        expect_eq("R4", 144'(cw[143:128]), 144'd0);
    endtask

    task automatic t_ones;
        logic [143:0] cw;
        push({128{1'b1}}, cw);
        check_code({128{1'b1}}, cw);
    endtask

    task automatic t_walk;
        logic [143:0] cw;
        for (int b = 0; b < 128; b++) begin
            push(128'd1 << b, cw);
            check_code(128'd1 << b, cw);
        end
    endtask

    task automatic t_random;
        logic [143:0] cw;
        logic [127:0] d;
        for (int n = 0; n < 200; n++) begin
            d = {$urandom, $urandom, $urandom, $urandom};
            push(d, cw);
            check_code(d, cw);
        end
    endtask

    task automatic t_linear;
        logic [143:0] ca, cb, cx;
        logic [127:0] a, b;
        for (int n = 0; n < 16; n++) begin
            a = {$urandom, $urandom, $urandom, $urandom};
            b = {$urandom, $urandom, $urandom, $urandom};
            push(a, ca);
            push(b, cb);
            push(a ^ b, cx);
            expect_eq("R5", cx, ca ^ cb);
        end
    endtask

    task automatic t_timing;
        logic [143:0] cw;
        @(negedge clk);
        expect_eq("R6", 144'(out_valid), 144'd0);
        push(128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, cw);
        expect_eq("R6", 144'(cw[127:0]), 144'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210);
        @(negedge clk);
        expect_eq("R6", 144'(out_valid), 144'd0);
    endtask

    task automatic t_hold;
        logic [143:0] cw;
        push(128'hA5A5_0F0F_3C3C_FFFF_0000_1234_5678_9ABC, cw);
        for (int n = 0; n < 5; n++) begin
            in_data = {$urandom, $urandom, $urandom, $urandom};
            @(negedge clk);
            expect_eq("R7", out_code, cw);
            expect_eq("R7", 144'(out_valid), 144'd0);
        end
    endtask

    initial begin
        t_reset();
        t_zero();
        t_ones();
        t_walk();
        t_random();
        t_linear();
        t_timing();
        t_hold();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule